// File: doc/BRIEF.md
# Serial Command and Configuration Loader

This block takes in a one-bit serial stream, one bit per rising edge of the data clock, while the interface counter reset is low. A frame-end strobe closes each transfer. The block counts the bits as they arrive. Transfer bit 0 is the first bit received, and bits 0 to 7 form the command byte. When the frame-end strobe arrives, the block looks at the bit count and at the command byte. From these it decides whether the transfer is a command-only byte, a command with a 24-bit configuration word, or a command with a 120-bit display-line frame. A transfer that fits none of these cases is dropped.

Command bits 0, 1 and 2 are the blank, set and sleep flags. Command bits 3 to 7 are the line address, and bit 3 is the address LSB. The configuration word is transfer bits 8 to 31. It appears on `cfgOut`, where `cfgOut[k]` holds transfer bit k+8. Its reset value is non-zero. Display frames are not stored inside the block. Each accepted frame produces a one-cycle write strobe, together with the line address and the 120 data bits, for a display memory outside the block. A copy of every input bit leaves on `sdo` one clock later, so that devices can be chained.

Top module: `serial_cfg_loader`

## Requirements
- R1: While general reset is high, and after it is released, the outputs hold these values: `cfgOut` = 24'h020340 (column-only, bit-order, video and sleep-2 set), blank, set and sleep 0, `rsvdErr` 0, `ramWe` 0 and `sdo` 0.
- R2: `sdo` equals the value of `sdi` sampled at the previous rising clock edge.
- R3: An 8-bit transfer whose bits 3 to 7 are all 1 copies bits 0, 1 and 2 to blank, set and sleep. It leaves `cfgOut` unchanged.
- R4: A 32-bit transfer is handled as command-only when bits 3 to 7 are all 1, even if bits 0 and 1 are both 1. Blank, set and sleep are updated, and `cfgOut` is left unchanged.
- R5: A 32-bit transfer with bits 0 and 1 both 1, whose address is not all ones, loads `cfgOut[k]` from transfer bit k+8 and sleep from bit 2. Blank and set are left unchanged.
- R6: A configuration load sets `rsvdErr` when any of transfer bits 26 to 30 (`cfgOut[22:18]`) is 1. A later load with those bits at 0 clears it.
- R7: A 128-bit transfer whose address is not all ones, arriving after a configuration load, raises `ramWe` for exactly one cycle. The pulse is in the cycle after the frame-end edge, and `ramAddr` then holds bits 3 to 7.
- R8: With `cfgOut[8]` = 1 (bit-order select), `ramData[j]` equals transfer bit 8+j. With `cfgOut[8]` = 0, `ramData[j]` equals transfer bit 127-j.
- R9: A 128-bit transfer that arrives before any configuration load since general reset produces no write.
- R10: A transfer of any length other than 8, 32 or 128 changes no output.
- R11: A pulse on the counter reset drops the bits received so far and keeps the configuration. A full transfer that follows is decoded normally.
- R12: A general reset after use restores the R1 values and clears the record that a configuration was loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock, rising edge |
| genRst | input | 1 | General reset, asynchronous, active high |
| cntRst | input | 1 | Serial bit counter reset, synchronous, active high |
| sdi | input | 1 | Serial data input |
| frameEnd | input | 1 | Transfer end strobe, one cycle, no bit taken in that cycle |
| sdo | output | 1 | Input bit delayed one clock, for chaining |
| blankOut | output | 1 | Blank flag |
| setOut | output | 1 | Set flag |
| sleepOut | output | 1 | Sleep flag |
| cfgOut | output | 24 | Configuration word, bit k = transfer bit k+8 |
| rsvdErr | output | 1 | Reserved configuration bits were written non-zero |
| ramWe | output | 1 | One-cycle line write strobe |
| ramAddr | output | 5 | Line address of the write |
| ramData | output | 120 | Line data of the write, order set by cfgOut[8] |

## Verification
The assertions rely on three assumptions about the inputs. First, `frameEnd` is never high in two cycles running. Second, `cntRst` is low on the frame-end edge of a transfer that should be decoded. Third, `sdi` settles away from the rising edge. The stimulus drives every input at the falling edge. It holds `cntRst` high whenever no transfer is running and drops it only for the bits of a transfer. Each frame-end strobe lasts exactly one cycle and is followed by idle time, so idle clocks never add to the bit count.

// File: rtl/slPkg.sv
package slPkg;
  typedef struct packed {
    logic takeBit;
    logic clrCnt;
    logic loadCmd;
    logic loadCfg;
    logic writeRam;
  } strobeT;
endpackage

// File: rtl/slCtrl.sv
module slCtrl
  import slPkg::*;
#(
  parameter int CMD_W     = 8,
  parameter int CFG_LEN   = 32,
  parameter int FRAME_LEN = 128,
  parameter int ADDR_W    = 5,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              genRst,
  input  logic              cntRst,
  input  logic              frameEnd,
  input  logic [ADDR_W-1:0] addrField,
  input  logic [1:0]        initPair,
  output strobeT            strb,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              initDone
);
  logic [CNT_W-1:0] cnt;
  logic addrAllOnes, evalNow, lenCmd, lenCfg, lenFrame;

  assign addrAllOnes = &addrField;
  assign evalNow     = frameEnd && !cntRst;
  assign lenCmd      = (cnt == CNT_W'(CMD_W));
  assign lenCfg      = (cnt == CNT_W'(CFG_LEN));
  assign lenFrame    = (cnt == CNT_W'(FRAME_LEN));
  assign bitCnt      = cnt;

  always_comb begin
    strb.takeBit  = !cntRst && !frameEnd;
    strb.clrCnt   = cntRst || frameEnd;
    // all-ones address wins over every other reading of the command byte
    strb.loadCmd  = evalNow && addrAllOnes && (lenCmd || lenCfg || lenFrame);
    strb.loadCfg  = evalNow && !addrAllOnes && lenCfg && (&initPair);
    strb.writeRam = evalNow && !addrAllOnes && lenFrame && initDone;
  end

  always_ff @(posedge clk or posedge genRst) begin
    if (genRst) begin
      cnt      <= '0;
      initDone <= 1'b0;
    end else begin
      if (strb.clrCnt)                     cnt <= '0;
      else if (strb.takeBit && cnt != '1)  cnt <= cnt + 1'b1;
      if (strb.loadCfg)                    initDone <= 1'b1;
    end
  end

  // R11
  cnt_zero_chk: assert property (@(posedge clk) disable iff (genRst)
    strb.clrCnt |=> (cnt == '0));
endmodule

// File: rtl/slData.sv
module slData
  import slPkg::*;
#(
  parameter int          CMD_W     = 8,
  parameter int          CFG_W     = 24,
  parameter int          PAY_W     = 120,
  parameter int          ADDR_W    = 5,
  parameter int          CNT_W     = 8,
  parameter int          ORDER_IDX = 8,
  parameter int          RSV_LO    = 18,
  parameter int          RSV_HI    = 22,
  parameter logic [23:0] CFG_INIT  = 24'h020340
) (
  input  logic              clk,
  input  logic              genRst,
  input  logic              sdi,
  input  strobeT            strb,
  input  logic [CNT_W-1:0]  bitCnt,
  output logic [ADDR_W-1:0] addrField,
  output logic [1:0]        initPair,
  output logic              sdo,
  output logic              blankOut,
  output logic              setOut,
  output logic              sleepOut,
  output logic [CFG_W-1:0]  cfgOut,
  output logic              rsvdErr,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [PAY_W-1:0]  ramData
);
  localparam int CMD_IDX_W = $clog2(CMD_W);
  localparam int PAY_IDX_W = $clog2(PAY_W);

  logic [CMD_W-1:0] cmdSh;
  logic [PAY_W-1:0] pay, revPay;
  logic [CFG_W-1:0] cfgReg;
  logic inCmd, inPay;

  assign inCmd     = bitCnt < CNT_W'(CMD_W);
  assign inPay     = bitCnt < CNT_W'(CMD_W + PAY_W);
  assign addrField = cmdSh[CMD_W-1 -: ADDR_W];
  assign initPair  = cmdSh[1:0];
  assign cfgOut    = cfgReg;

  for (genvar j = 0; j < PAY_W; j++) begin : gRev
    assign revPay[j] = pay[PAY_W-1-j];
  end

  always_ff @(posedge clk or posedge genRst) begin
    if (genRst) begin
      cmdSh    <= '0;
      pay      <= '0;
      sdo      <= 1'b0;
      blankOut <= 1'b0;
      setOut   <= 1'b0;
      sleepOut <= 1'b0;
      cfgReg   <= CFG_INIT;
      rsvdErr  <= 1'b0;
      ramWe    <= 1'b0;
      ramAddr  <= '0;
      ramData  <= '0;
    end else begin
      sdo   <= sdi;
      ramWe <= strb.writeRam;
      if (strb.takeBit) begin
        if (inCmd)      cmdSh[bitCnt[CMD_IDX_W-1:0]] <= sdi;
        else if (inPay) pay[PAY_IDX_W'(bitCnt - CNT_W'(CMD_W))] <= sdi;
      end
      if (strb.loadCmd) begin
        blankOut <= cmdSh[0];
        setOut   <= cmdSh[1];
        sleepOut <= cmdSh[2];
      end
      if (strb.loadCfg) begin
        cfgReg   <= pay[CFG_W-1:0];
        sleepOut <= cmdSh[2];
        rsvdErr  <= |pay[RSV_HI:RSV_LO];
      end
      if (strb.writeRam) begin
        ramAddr <= addrField;
        ramData <= cfgReg[ORDER_IDX] ? pay : revPay;
      end
    end
  end

  // R2
  sdo_echo_chk: assert property (@(posedge clk) disable iff (genRst)
    1'b1 |=> (sdo == $past(sdi)));
  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (genRst)
    !strb.loadCfg |=> $stable(cfgReg));
  // R6
  rsvd_flag_chk: assert property (@(posedge clk) disable iff (genRst)
    $rose(rsvdErr) |-> $past(strb.loadCfg));
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import slPkg::*;
#(
  parameter int          CMD_W      = 8,
  parameter int          CFG_LEN    = 32,
  parameter int          FRAME_LEN  = 128,
  parameter int          ADDR_W     = 5,
  parameter int          ORDER_POS  = 16,
  parameter int          RSV_LO_POS = 26,
  parameter int          RSV_HI_POS = 30,
  parameter logic [23:0] CFG_INIT   = 24'h020340
) (
  input  logic                       clk,
  input  logic                       genRst,
  input  logic                       cntRst,
  input  logic                       sdi,
  input  logic                       frameEnd,
  output logic                       sdo,
  output logic                       blankOut,
  output logic                       setOut,
  output logic                       sleepOut,
  output logic [CFG_LEN-CMD_W-1:0]   cfgOut,
  output logic                       rsvdErr,
  output logic                       ramWe,
  output logic [ADDR_W-1:0]          ramAddr,
  output logic [FRAME_LEN-CMD_W-1:0] ramData
);
  localparam int CFG_W = CFG_LEN - CMD_W;
  localparam int PAY_W = FRAME_LEN - CMD_W;
  localparam int CNT_W = $clog2(FRAME_LEN) + 1;

  strobeT            strb;
  logic [CNT_W-1:0]  bitCnt;
  logic [ADDR_W-1:0] addrField;
  logic [1:0]        initPair;
  logic              initDone;

  slCtrl #(
    .CMD_W(CMD_W), .CFG_LEN(CFG_LEN), .FRAME_LEN(FRAME_LEN),
    .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .genRst(genRst), .cntRst(cntRst), .frameEnd(frameEnd),
    .addrField(addrField), .initPair(initPair),
    .strb(strb), .bitCnt(bitCnt), .initDone(initDone)
  );

  slData #(
    .CMD_W(CMD_W), .CFG_W(CFG_W), .PAY_W(PAY_W), .ADDR_W(ADDR_W),
    .CNT_W(CNT_W), .ORDER_IDX(ORDER_POS - CMD_W),
    .RSV_LO(RSV_LO_POS - CMD_W), .RSV_HI(RSV_HI_POS - CMD_W),
    .CFG_INIT(CFG_INIT)
  ) uData (
    .clk(clk), .genRst(genRst), .sdi(sdi), .strb(strb), .bitCnt(bitCnt),
    .addrField(addrField), .initPair(initPair), .sdo(sdo),
    .blankOut(blankOut), .setOut(setOut), .sleepOut(sleepOut),
    .cfgOut(cfgOut), .rsvdErr(rsvdErr), .ramWe(ramWe),
    .ramAddr(ramAddr), .ramData(ramData)
  );

  // R7
  write_pulse_chk: assert property (@(posedge clk) disable iff (genRst)
    ramWe |=> !ramWe);
  // R9
  write_after_init_chk: assert property (@(posedge clk) disable iff (genRst)
    ramWe |-> initDone);
endmodule

// File: tb/tb_serial_cfg_loader.sv
module tb_serial_cfg_loader;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic genRst = 1'b1, cntRst = 1'b1, sdi = 1'b0, frameEnd = 1'b0;
  logic sdo, blankOut, setOut, sleepOut, rsvdErr, ramWe;
  logic [23:0]  cfgOut;
  logic [4:0]   ramAddr;
  logic [119:0] ramData;

  int total = 0, bad = 0;
  logic sdiAtEdge = 1'b0;
  logic [4:0]   addrQ[$];
  logic [119:0] dataQ[$];

  serial_cfg_loader dut (
    .clk(clk), .genRst(genRst), .cntRst(cntRst), .sdi(sdi), .frameEnd(frameEnd),
    .sdo(sdo), .blankOut(blankOut), .setOut(setOut), .sleepOut(sleepOut),
    .cfgOut(cfgOut), .rsvdErr(rsvdErr), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramData(ramData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) sdiAtEdge <= sdi;

  // monitor: echo output and scoreboard of line writes
  always @(negedge clk) begin
    if (!genRst) check("R2 sdo echo", 128'(sdo), 128'(sdiAtEdge));
    if (!genRst && ramWe) begin
      if (addrQ.size() == 0) check("R9 unexpected write", 128'(ramWe), 128'(0));
      else begin
        logic [4:0]   ea;
        logic [119:0] ed;
        ea = addrQ.pop_front();
        ed = dataQ.pop_front();
        check("R7 write addr", 128'(ramAddr), 128'(ea));
        check("R8 write data", 128'(ramData), 128'(ed));
      end
    end
  end

  function automatic logic [127:0] mkCfg(input logic slp, input logic [4:0] a, input logic [23:0] c);
    logic [127:0] v = '0;
    v[0] = 1'b1; v[1] = 1'b1; v[2] = slp; v[7:3] = a; v[31:8] = c;
    return v;
  endfunction

  function automatic logic [127:0] mkFrame(input logic [4:0] a, input logic [119:0] d);
    logic [127:0] v = '0;
    v[7:3] = a; v[127:8] = d;
    return v;
  endfunction

  function automatic logic [119:0] rev(input logic [119:0] d);
    logic [119:0] r;
    for (int j = 0; j < 120; j++) r[j] = d[119-j];
    return r;
  endfunction

  task automatic xfer(input logic [127:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cntRst = 1'b0; sdi = v[i];
    end
    @(negedge clk); sdi = 1'b0; frameEnd = 1'b1;
    @(negedge clk); frameEnd = 1'b0; cntRst = 1'b1;
  endtask

  task automatic doReset();
    genRst = 1'b1; cntRst = 1'b1; sdi = 1'b0; frameEnd = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 cfg", 128'(cfgOut), 128'(24'h020340));
    genRst = 1'b0;
    @(negedge clk);
    check("R1 cfg", 128'(cfgOut), 128'(24'h020340));
    check("R1 flags", 128'({blankOut, setOut, sleepOut, rsvdErr, ramWe, sdo}), 128'(0));
  endtask

  initial begin
    logic [119:0] d1, d2;
    d1 = {30'h2A5A5A5A, 30'h13C3C3C3, 30'h0F0F00FF, 30'h3FFF0001};
    d2 = {60'h0123456789ABCDE, 60'hFEDCBA987654321};

    doReset();

    // R9: frame before any configuration
    xfer(mkFrame(5'd3, d1), 128);
    check("R9 no write before config", 128'(ramWe), 128'(0));

    // R4: all-ones address overrides configuration reading
    xfer(mkCfg(1'b1, 5'h1F, 24'hFFFFFF), 32);
    check("R4 cfg kept", 128'(cfgOut), 128'(24'h020340));
    check("R4 flags", 128'({blankOut, setOut, sleepOut}), 128'(3'b111));

    // R3: command-only byte, blank=0 set=1 sleep=0
    xfer(128'hFA, 8);
    check("R3 flags", 128'({blankOut, setOut, sleepOut}), 128'(3'b010));
    check("R3 cfg kept", 128'(cfgOut), 128'(24'h020340));

    // R10: wrong lengths dropped
    xfer(mkCfg(1'b1, 5'd2, 24'h000000), 31);
    xfer(mkCfg(1'b1, 5'd2, 24'h000000), 33);
    xfer(128'h07, 16);
    check("R10 cfg kept", 128'(cfgOut), 128'(24'h020340));
    check("R10 flags kept", 128'({blankOut, setOut, sleepOut}), 128'(3'b010));

    // R5: configuration load, order bit set
    xfer(mkCfg(1'b0, 5'd5, 24'h03A5C3), 32);
    check("R5 cfg", 128'(cfgOut), 128'(24'h03A5C3));
    check("R5 flags", 128'({blankOut, setOut, sleepOut}), 128'(3'b010));
    check("R6 clean", 128'(rsvdErr), 128'(0));

    // R7 R8: frame write, straight order
    addrQ.push_back(5'd13); dataQ.push_back(d1);
    xfer(mkFrame(5'd13, d1), 128);
    check("R7 pulse high", 128'(ramWe), 128'(1));
    @(negedge clk);
    check("R7 pulse one cycle", 128'(ramWe), 128'(0));

    // R6: reserved bit set, order bit cleared
    xfer(mkCfg(1'b1, 5'd0, 24'h1034C2), 32);
    check("R6 flag", 128'(rsvdErr), 128'(1));
    check("R5 cfg2", 128'(cfgOut), 128'(24'h1034C2));
    check("R5 sleep", 128'(sleepOut), 128'(1));

    // R8: reversed order
    addrQ.push_back(5'd0); dataQ.push_back(rev(d2));
    xfer(mkFrame(5'd0, d2), 128);
    check("R8 pulse", 128'(ramWe), 128'(1));

    xfer(mkCfg(1'b0, 5'd1, 24'h03A5C3), 32);
    check("R6 cleared", 128'(rsvdErr), 128'(0));

    // R11: counter reset mid-transfer
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); cntRst = 1'b0; sdi = i[0];
    end
    @(negedge clk); cntRst = 1'b1;
    @(negedge clk);
    check("R11 cfg kept", 128'(cfgOut), 128'(24'h03A5C3));
    xfer(mkCfg(1'b0, 5'd9, 24'h00F10F), 32);
    check("R11 later load", 128'(cfgOut), 128'(24'h00F10F));

    // R12: general reset after use
    doReset();
    check("R12 cfg", 128'(cfgOut), 128'(24'h020340));
    xfer(mkFrame(5'd4, d2), 128);
    check("R12 no write", 128'(ramWe), 128'(0));

    repeat (3) @(negedge clk);
    check("R7 queue drained", 128'(addrQ.size()), 128'(0));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule